// File: doc/BRIEF.md
# Page-Table Entry Accessed/Dirty Update Unit

This block runs after a page-table walk has fetched a leaf entry and checked its permissions. It chooses one of three results. It can set the Accessed and Dirty bits in hardware and write the entry back. It can raise a page fault. It can pass the entry through unchanged. The write-back is an atomic compare-and-swap against the value the walk read. If memory no longer holds that value, the unit asks the walker to redo the walk.

Two static straps pick the policy. `strap_svadu` makes a software-visible update-enable bit exist in the machine environment register. `strap_svade` picks the default, or the forced policy when that bit does not exist. This gives four modes:

| `strap_svade` | `strap_svadu` | Behaviour |
|---|---|---|
| 0 | 0 | Hardware updating, and it cannot be turned off. |
| 0 | 1 | Hardware updating by default. Software may turn it off. |
| 1 | 0 | Fault mode, and it cannot be changed. |
| 1 | 1 | Fault mode by default. Software may turn hardware updating on. |

A second enable bit, held for the hypervisor level, further gates the first stage of a two-stage translation while virtualization is active.

Top module: `pte_adu`

## Requirements
- R1: After reset, bit 61 of `menv_rdata` reads 1 exactly when `strap_svadu`=1 and `strap_svade`=0. `henv_rdata` reads all zeros. All bits other than bit 61 of both registers always read zero.
- R2: A write loads bit 61 of the write data into the matching register's enable bit only when `strap_svadu`=1. When `strap_svadu`=0 the write is ignored and bit 61 reads 0.
- R3: The effective update enable is the machine enable bit when `strap_svadu`=1, and the inverse of `strap_svade` when `strap_svadu`=0. When `req_first_stage`, `req_two_stage` and `req_virt` are all 1, the effective enable is also ANDed with the hypervisor enable bit.
- R4: With the enable on, the final entry has Accessed (bit 6) set. When `req_store`=1 it also has Dirty (bit 7) set. All other bits equal the input entry.
- R5: With the enable off, the result is a fault (status 1, `rsp_pte` = input entry) when bit 6 is clear, or when `req_store`=1 and bit 7 is clear. Otherwise the result is status 0 with the entry unmodified.
- R6: A memory request is issued only when the final entry differs from the input and `req_debug`=0. Otherwise the response comes back without a memory request.
- R7: The memory request carries `mem_req_addr` = `req_addr`, `mem_req_cmp` = the input entry and `mem_req_swap` = the updated entry. It is held stable until `mem_req_ready`.
- R8: A memory response with `mem_rsp_match`=1 gives status 0 with the updated entry. A response with `mem_rsp_match`=0 gives status 2 (restart) with the input entry.
- R9: The unit accepts one request at a time. `req_ready` is high only when the unit is idle. A response stays valid and stable until `rsp_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_svade | input | 1 | Static strap: fault-mode default |
| strap_svadu | input | 1 | Static strap: enable bit present |
| menv_we | input | 1 | Machine environment register write |
| menv_wdata | input | 64 | Machine environment write data |
| menv_rdata | output | 64 | Machine environment read value |
| henv_we | input | 1 | Hypervisor environment register write |
| henv_wdata | input | 64 | Hypervisor environment write data |
| henv_rdata | output | 64 | Hypervisor environment read value |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_pte | input | 64 | Leaf entry as read by the walk |
| req_store | input | 1 | Access is a data store |
| req_debug | input | 1 | Debug access, never writes memory |
| req_addr | input | ADDR_W | Physical address of the entry |
| req_first_stage | input | 1 | Entry belongs to the first stage |
| req_two_stage | input | 1 | Two-stage translation in use |
| req_virt | input | 1 | Virtualization active |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken |
| rsp_status | output | 2 | 0 ok, 1 fault, 2 restart |
| rsp_pte | output | 64 | Final entry |
| mem_req_valid | output | 1 | Compare-and-swap request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDR_W | Entry address |
| mem_req_cmp | output | 64 | Expected memory value |
| mem_req_swap | output | 64 | Value to store on match |
| mem_rsp_valid | input | 1 | Compare-and-swap result valid |
| mem_rsp_match | input | 1 | Memory matched and was written |

## Verification
The bench runs all four strap modes. Each mode starts from a fresh reset and tries writes of ones and zeros to the enable bits. A design with a wrong reset or a wrong write mask would show a bit 61 that ignores the straps.

Random entries are sent with random store, debug and stage flags. This covers several cases that a broken design would get wrong:
- A debug access that would change the entry. A broken design would write memory anyway.
- A store to an entry that already has Accessed and Dirty set. This must not issue a write.
- The virtualized first stage with the hypervisor bit clear. A broken design would update when it should fault.
- A compare-and-swap mismatch. A design that reports a fault here would lose the restart.

// File: rtl/pte_adu_pkg.sv
package pte_adu_pkg;
    localparam int PTE_W    = 64;
    localparam int A_POS    = 6;
    localparam int D_POS    = 7;
    localparam int ADUE_POS = 61;

    typedef enum logic [1:0] {
        RES_OK      = 2'd0,
        RES_FAULT   = 2'd1,
        RES_RESTART = 2'd2
    } result_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CAS,
        ST_WAIT,
        ST_RESP
    } fsm_e;
endpackage

// File: rtl/pte_adu_envcfg.sv
module pte_adu_envcfg
    import pte_adu_pkg::*;
#(
    parameter int XLEN  = PTE_W,
    parameter int EN_AT = ADUE_POS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            svade,
    input  logic            svadu,
    input  logic            m_we,
    input  logic [XLEN-1:0] m_wdata,
    input  logic            h_we,
    input  logic [XLEN-1:0] h_wdata,
    output logic [XLEN-1:0] m_rdata,
    output logic [XLEN-1:0] h_rdata,
    output logic            m_en,
    output logic            h_en
);
    typedef struct packed {
        logic m_bit;
        logic h_bit;
    } env_t;

    env_t env_d, env_q;

    always_comb begin
        env_d = env_q;
        if (m_we) env_d.m_bit = svadu & m_wdata[EN_AT];
        if (h_we) env_d.h_bit = svadu & h_wdata[EN_AT];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            env_q.m_bit <= svadu & ~svade;
            env_q.h_bit <= 1'b0;
        end else begin
            env_q <= env_d;
        end
    end

    always_comb begin
        m_rdata        = '0;
        h_rdata        = '0;
        m_rdata[EN_AT] = env_q.m_bit;
        h_rdata[EN_AT] = env_q.h_bit;
    end

    assign m_en = env_q.m_bit;
    assign h_en = env_q.h_bit;

    // R2: without the strap, a write must not leave the bit set
    assert_absent_reads_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!svadu && m_we) |=> !m_rdata[EN_AT]);
endmodule

// File: rtl/pte_adu_decide.sv
module pte_adu_decide
    import pte_adu_pkg::*;
#(
    parameter int W   = PTE_W,
    parameter int AP  = A_POS,
    parameter int DP  = D_POS
) (
    input  logic         svade,
    input  logic         svadu,
    input  logic         m_en,
    input  logic         h_en,
    input  logic [W-1:0] pte,
    input  logic         store,
    input  logic         debug,
    input  logic         first_stage,
    input  logic         two_stage,
    input  logic         virt,
    output logic [W-1:0] new_pte,
    output logic         fault,
    output logic         need_write
);
    logic         base_en;
    logic         eff_en;
    logic [W-1:0] set_mask;

    always_comb begin
        base_en = svadu ? m_en : ~svade;
        eff_en  = base_en;
        if (first_stage && two_stage && virt) eff_en = base_en & h_en;

        set_mask     = '0;
        set_mask[AP] = 1'b1;
        set_mask[DP] = store;

        new_pte    = eff_en ? (pte | set_mask) : pte;
        fault      = ~eff_en & (~pte[AP] | (store & ~pte[DP]));
        need_write = ~fault & ~debug & (new_pte != pte);
    end
endmodule

// File: rtl/pte_adu_ctrl.sv
module pte_adu_ctrl
    import pte_adu_pkg::*;
#(
    parameter int W      = PTE_W,
    parameter int ADDR_W = 56,
    parameter int AP     = A_POS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [W-1:0]      req_pte,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [W-1:0]      dec_pte,
    input  logic              dec_fault,
    input  logic              dec_write,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [1:0]        rsp_status,
    output logic [W-1:0]      rsp_pte,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [W-1:0]      mem_req_cmp,
    output logic [W-1:0]      mem_req_swap,
    input  logic              mem_rsp_valid,
    input  logic              mem_rsp_match
);
    typedef struct packed {
        fsm_e              st;
        logic [W-1:0]      orig;
        logic [W-1:0]      upd;
        logic [ADDR_W-1:0] addr;
        result_e           res;
    } ctl_t;

    ctl_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        unique case (c_q.st)
            ST_IDLE: if (req_valid) begin
                c_d.orig = req_pte;
                c_d.upd  = dec_pte;
                c_d.addr = req_addr;
                if (dec_fault) begin
                    c_d.res = RES_FAULT;
                    c_d.upd = req_pte;
                    c_d.st  = ST_RESP;
                end else if (dec_write) begin
                    c_d.st  = ST_CAS;
                end else begin
                    c_d.res = RES_OK;
                    c_d.st  = ST_RESP;
                end
            end
            ST_CAS: if (mem_req_ready) c_d.st = ST_WAIT;
            ST_WAIT: if (mem_rsp_valid) begin
                if (mem_rsp_match) begin
                    c_d.res = RES_OK;
                end else begin
                    c_d.res = RES_RESTART;
                    c_d.upd = c_q.orig;
                end
                c_d.st = ST_RESP;
            end
            ST_RESP: if (rsp_ready) c_d.st = ST_IDLE;
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q.st   <= ST_IDLE;
            c_q.orig <= '0;
            c_q.upd  <= '0;
            c_q.addr <= '0;
            c_q.res  <= RES_OK;
        end else begin
            c_q <= c_d;
        end
    end

    assign req_ready     = (c_q.st == ST_IDLE);
    assign rsp_valid     = (c_q.st == ST_RESP);
    assign rsp_status    = c_q.res;
    assign rsp_pte       = c_q.upd;
    assign mem_req_valid = (c_q.st == ST_CAS);
    assign mem_req_addr  = c_q.addr;
    assign mem_req_cmp   = c_q.orig;
    assign mem_req_swap  = c_q.upd;

    assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_pte) && $stable(rsp_status)));

    assert_one_phase_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && (rsp_valid || mem_req_valid)));

    assert_ok_has_accessed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status == RES_OK) |-> rsp_pte[AP]);

    assert_cas_changes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_swap != mem_req_cmp));

    assert_cas_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_swap) && $stable(mem_req_cmp)));
endmodule

// File: rtl/pte_adu.sv
module pte_adu
    import pte_adu_pkg::*;
#(
    parameter int ADDR_W = 56
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_svade,
    input  logic              strap_svadu,
    input  logic              menv_we,
    input  logic [63:0]       menv_wdata,
    output logic [63:0]       menv_rdata,
    input  logic              henv_we,
    input  logic [63:0]       henv_wdata,
    output logic [63:0]       henv_rdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [63:0]       req_pte,
    input  logic              req_store,
    input  logic              req_debug,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_first_stage,
    input  logic              req_two_stage,
    input  logic              req_virt,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [1:0]        rsp_status,
    output logic [63:0]       rsp_pte,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [63:0]       mem_req_cmp,
    output logic [63:0]       mem_req_swap,
    input  logic              mem_rsp_valid,
    input  logic              mem_rsp_match
);
    logic        m_en, h_en;
    logic [63:0] dec_pte;
    logic        dec_fault, dec_write;

    pte_adu_envcfg #(.XLEN(64), .EN_AT(ADUE_POS)) u_env (
        .clk(clk), .rst_n(rst_n), .svade(strap_svade), .svadu(strap_svadu),
        .m_we(menv_we), .m_wdata(menv_wdata), .h_we(henv_we), .h_wdata(henv_wdata),
        .m_rdata(menv_rdata), .h_rdata(henv_rdata), .m_en(m_en), .h_en(h_en)
    );

    pte_adu_decide #(.W(64), .AP(A_POS), .DP(D_POS)) u_dec (
        .svade(strap_svade), .svadu(strap_svadu), .m_en(m_en), .h_en(h_en),
        .pte(req_pte), .store(req_store), .debug(req_debug),
        .first_stage(req_first_stage), .two_stage(req_two_stage), .virt(req_virt),
        .new_pte(dec_pte), .fault(dec_fault), .need_write(dec_write)
    );

    pte_adu_ctrl #(.W(64), .ADDR_W(ADDR_W), .AP(A_POS)) u_ctl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_pte(req_pte), .req_addr(req_addr),
        .dec_pte(dec_pte), .dec_fault(dec_fault), .dec_write(dec_write),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_status(rsp_status), .rsp_pte(rsp_pte),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_req_cmp(mem_req_cmp), .mem_req_swap(mem_req_swap),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_match(mem_rsp_match)
    );
endmodule

// File: tb/pte_adu_test.sv
`timescale 1ns/1ps
module pte_adu_test;
    localparam int AW = 56;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic strap_svade = 1'b0, strap_svadu = 1'b0;
    logic menv_we = 1'b0, henv_we = 1'b0;
    logic [63:0] menv_wdata = '0, henv_wdata = '0, menv_rdata, henv_rdata;
    logic req_valid = 1'b0, req_ready, req_store = 1'b0, req_debug = 1'b0;
    logic [63:0] req_pte = '0;
    logic [AW-1:0] req_addr = '0;
    logic req_first_stage = 1'b0, req_two_stage = 1'b0, req_virt = 1'b0;
    logic rsp_valid, rsp_ready = 1'b0;
    logic [1:0] rsp_status;
    logic [63:0] rsp_pte, mem_req_cmp, mem_req_swap;
    logic mem_req_valid, mem_req_ready = 1'b0, mem_rsp_valid = 1'b0, mem_rsp_match = 1'b0;
    logic [AW-1:0] mem_req_addr;

    int tests = 0, fails = 0;
    logic m_sh, h_sh;

    always #2.5 clk = ~clk;

    pte_adu #(.ADDR_W(AW)) uut (.*);

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial begin
        #(5.0 * 200000);
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    task automatic do_reset(input logic e, input logic u);
        @(negedge clk);
        rst_n = 1'b0; strap_svade = e; strap_svadu = u;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_sh = u & ~e; h_sh = 1'b0;
        chk(menv_rdata == {2'b0, m_sh, 61'b0}, "R1 menv reset", menv_rdata, {2'b0, m_sh, 61'b0});
        chk(henv_rdata == 64'd0, "R1 henv reset", henv_rdata, 64'd0);
    endtask

    task automatic env_write(input bit hyp, input logic [63:0] v);
        @(negedge clk);
        if (hyp) begin henv_we = 1'b1; henv_wdata = v; end
        else     begin menv_we = 1'b1; menv_wdata = v; end
        @(negedge clk);
        henv_we = 1'b0; menv_we = 1'b0;
        if (hyp) h_sh = strap_svadu & v[61];
        else     m_sh = strap_svadu & v[61];
        chk(menv_rdata == {2'b0, m_sh, 61'b0}, "R2 menv write", menv_rdata, {2'b0, m_sh, 61'b0});
        chk(henv_rdata == {2'b0, h_sh, 61'b0}, "R2 henv write", henv_rdata, {2'b0, h_sh, 61'b0});
    endtask

    function automatic logic eff_en(input logic fs, input logic ts, input logic vi);
        logic b;
        b = strap_svadu ? m_sh : ~strap_svade;
        if (fs && ts && vi) b = b & h_sh;
        return b;
    endfunction

    task automatic txn(input logic [63:0] pte, input logic st, input logic dbg,
                       input logic fs, input logic ts, input logic vi, input logic mism);
        logic en, flt, wr, saw, got;
        logic [63:0] upd, exp_pte;
        logic [1:0] exp_st;
        logic [AW-1:0] a;
        en  = eff_en(fs, ts, vi);
        upd = en ? (pte | 64'h40 | (st ? 64'h80 : 64'h0)) : pte;
        flt = ~en & (~pte[6] | (st & ~pte[7]));
        wr  = ~flt & ~dbg & (upd != pte);
        exp_st  = flt ? 2'd1 : ((wr && mism) ? 2'd2 : 2'd0);
        exp_pte = (flt || (wr && mism)) ? pte : upd;
        a = {$urandom, $urandom};
        @(negedge clk);
        chk(req_ready == 1'b1, "R9 ready when idle", {63'd0, req_ready}, 64'd1);
        req_valid = 1'b1; req_pte = pte; req_store = st; req_debug = dbg; req_addr = a;
        req_first_stage = fs; req_two_stage = ts; req_virt = vi;
        @(negedge clk);
        req_valid = 1'b0;
        saw = 1'b0; got = 1'b0;
        for (int i = 0; i < 40 && !got; i++) begin
            if (mem_req_valid) begin
                saw = 1'b1;
                chk(mem_req_addr == a, "R7 cas addr", {8'd0, mem_req_addr}, {8'd0, a});
                chk(mem_req_cmp == pte, "R7 cas compare", mem_req_cmp, pte);
                chk(mem_req_swap == upd, "R4 cas swap", mem_req_swap, upd);
                repeat ($urandom % 3) @(negedge clk);
                mem_req_ready = 1'b1;
                @(negedge clk);
                mem_req_ready = 1'b0; mem_rsp_valid = 1'b1; mem_rsp_match = ~mism;
                @(negedge clk);
                mem_rsp_valid = 1'b0;
            end else if (rsp_valid) begin
                got = 1'b1;
                chk(rsp_status == exp_st, "R5 R8 status", {62'd0, rsp_status}, {62'd0, exp_st});
                chk(rsp_pte == exp_pte, "R3 R4 final pte", rsp_pte, exp_pte);
                repeat ($urandom % 2) @(negedge clk);
                chk(rsp_valid && rsp_pte == exp_pte, "R9 response held", rsp_pte, exp_pte);
                rsp_ready = 1'b1;
                @(negedge clk);
                rsp_ready = 1'b0;
            end else begin
                @(negedge clk);
            end
        end
        chk(got, "R9 response seen", {63'd0, got}, 64'd1);
        chk(saw == wr, "R6 write issued", {63'd0, saw}, {63'd0, wr});
    endtask

    initial begin
        void'($urandom(32'd1234));
        for (int m = 0; m < 4; m++) begin
            do_reset(m[1], m[0]);
            env_write(1'b0, 64'hFFFF_FFFF_FFFF_FFFF);
            env_write(1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
            // R4: enable forced or set; store to clean entry sets A and D
            txn(64'h1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
            // R6: A and D already set, store, nothing to write
            txn(64'hC1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
            // R6: debug access never writes
            txn(64'h1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
            // R8: compare mismatch gives restart
            txn(64'h3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
            env_write(1'b1, 64'h0);
            // R3: virtualized first stage gated by hypervisor bit
            txn(64'h1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
            env_write(1'b0, 64'h0);
            // R5: load to entry with A set, store to entry with D clear
            txn(64'h41, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
            txn(64'h41, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
            for (int k = 0; k < 60; k++) begin
                logic [31:0] r;
                r = $urandom;
                if (r[3:0] == 4'd0) env_write(r[4], {$urandom, $urandom});
                txn({$urandom, $urandom}, r[5], (r[8:6] == 3'd0), r[9], r[10], r[11], (r[14:12] == 3'd0));
            end
        end
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule